// File: doc/BRIEF.md
# Oversampled Serial Bit Retimer

This block receives a slow serial link, a bit clock of about 2.048 MHz and its data line, and turns it into strobes in a fast system clock domain of about 50 MHz. The link clock never clocks a register. It is treated as an ordinary input. It passes through a two-stage synchroniser and then an edge detector. The active edge of the link clock, rising or falling as chosen by a parameter, becomes a bit-enable that lasts one system cycle. The data line is sampled a programmable number of system cycles after that enable, which moves the sample point towards the centre of the bit.

Each captured bit is presented as a one-cycle bit strobe with its value. The bits also shift, most significant first, into a word register of parameterised width. A word strobe marks every Nth bit. The delayed capture can still be pending when the next active edge arrives. In that case the delay restarts from the new edge and a sticky overrun flag is raised.

Both output streams carry a valid strobe and no ready. The serial link cannot be paused, so back-pressure has nowhere to go. A consumer must take every strobe in the cycle it is high. The bit value and the word are only defined in their strobe cycle, except that the word output holds its value between word strobes. The data line has no synchroniser of its own. It must be stable from the active link edge until the programmed sample point.

Top module: `serial_retimer`

## Requirements
- R1: After a synchronous reset, no bit strobe is produced until the link clock makes a real transition to its active level. A link clock held at the active level through reset and release gives no strobe.
- R2: Exactly one bit strobe is produced per active edge of the link clock. The edge is rising when EDGE_POL is EDGE_RISE and falling when it is EDGE_FALL.
- R3: While reset is high and in the first cycle after it, bit_vld, word_vld and overrun are 0. The word output reads 0 until the first word completes.
- R4: Suppose the link clock changes to its active level before system clock edge E0. Then the data line is sampled at edge E0+2+D, where D is samp_dly, and bit_vld is high in the cycle that follows that edge.
- R5: bit_vld is high for a single cycle, and bit_dat carries the sampled data value in that cycle.
- R6: Captured bits shift into the word most significant bit first. On every WORD_W-th bit since reset, word_vld rises together with that bit's bit_vld and word_dat shows the new word. word_dat holds its value until the next word.
- R7: An active edge that arrives while a delayed capture is pending drops that capture and restarts the delay from the new edge. It also sets overrun, which stays at 1 until reset.
- R8: With samp_dly = 0, the data line is sampled in the same cycle the bit-enable is high, with no extra delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk | input | 1 | Link bit clock, sampled as data |
| ser_dat | input | 1 | Link data line |
| samp_dly | input | DLY_W | Sample delay in system cycles after the bit-enable, must be below the bit period minus 3 |
| bit_vld | output | 1 | One-cycle strobe for a captured bit |
| bit_dat | output | 1 | Captured bit value, valid with bit_vld |
| word_vld | output | 1 | One-cycle strobe when a word completes |
| word_dat | output | WORD_W | Last completed word, MSB first |
| overrun | output | 1 | Sticky flag: an edge came while a capture was pending |

## Verification
Several properties are checked on every cycle by the assertions: the edge pulse never lasts two cycles, the pending delay counts down by one each cycle, overrun never falls back and always follows a restarted delay, a word strobe only appears together with a bit strobe, the word holds its value between strobes, and all strobes are clear right after reset. The bench scenarios are the only way to show the rest. These are the exact capture cycle for each delay, the correct bit value under varied bit periods, the MSB-first word contents, the absence of a false edge for each reset level, the falling-edge variant, and the dropped capture in an overrun.

// File: rtl/sr_pkg.sv
package sr_pkg;

  typedef enum logic {
    EDGE_FALL = 1'b0,
    EDGE_RISE = 1'b1
  } edge_pol_e;

  function automatic logic edge_hit(edge_pol_e pol, logic now_v, logic was_v);
    if (pol == EDGE_RISE) return now_v & ~was_v;
    else                  return ~now_v & was_v;
  endfunction

endpackage

// File: rtl/sr_sync.sv
module sr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout,
  output logic dout_ok
);
  logic [STAGES-1:0] chain;
  logic [STAGES-1:0] fill;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '0;
      fill  <= '0;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      fill  <= {fill[STAGES-2:0], 1'b1};
    end
  end

  assign dout    = chain[STAGES-1];
  assign dout_ok = fill[STAGES-1];

  // R1: the output is not reported valid until the chain has flushed
  a_r1_fill_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !dout_ok);
endmodule

// File: rtl/sr_edge.sv
module sr_edge #(
  parameter sr_pkg::edge_pol_e EDGE_POL = sr_pkg::EDGE_RISE
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  input  logic lvl_ok,
  output logic pulse
);
  logic hist;
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist  <= 1'b0;
      armed <= 1'b0;
    end else begin
      hist  <= lvl;
      armed <= lvl_ok;
    end
  end

  assign pulse = armed & sr_pkg::edge_hit(EDGE_POL, lvl, hist);

  a_r2_pulse_one_cycle: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);

  a_r1_no_pulse_post_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !pulse);
endmodule

// File: rtl/sr_sampler.sv
module sr_sampler #(
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fire,
  input  logic [DLY_W-1:0] dly,
  input  logic             din,
  output logic             cap,
  output logic             bit_vld,
  output logic             bit_dat,
  output logic             overrun
);
  logic             pend;
  logic [DLY_W-1:0] cnt;

  // A new edge always wins over a pending capture (R7); zero delay samples now (R8)
  assign cap = fire ? (dly == '0) : (pend && cnt == DLY_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      cnt     <= '0;
      bit_vld <= 1'b0;
      bit_dat <= 1'b0;
      overrun <= 1'b0;
    end else begin
      bit_vld <= cap;
      if (cap) bit_dat <= din;
      if (fire) begin
        if (pend) overrun <= 1'b1;
        pend <= (dly != '0);
        cnt  <= dly;
      end else if (pend) begin
        if (cnt == DLY_W'(1)) pend <= 1'b0;
        cnt <= cnt - DLY_W'(1);
      end
    end
  end

  a_r4_countdown: assert property (@(posedge clk) disable iff (rst)
    (pend && !fire && cnt > DLY_W'(1)) |=> (pend && cnt == $past(cnt) - DLY_W'(1)));

  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

  a_r7_restart_flags: assert property (@(posedge clk) disable iff (rst)
    (fire && pend) |=> overrun);
endmodule

// File: rtl/sr_packer.sv
module sr_packer #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cap,
  input  logic              bit_in,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_dat
);
  localparam int CW = $clog2(WORD_W);

  logic [WORD_W-1:0] sh;
  logic [WORD_W-1:0] sh_next;
  logic [CW-1:0]     cnt;
  logic              last;

  assign sh_next = {sh[WORD_W-2:0], bit_in};
  assign last    = (cnt == CW'(WORD_W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sh       <= '0;
      cnt      <= '0;
      word_vld <= 1'b0;
      word_dat <= '0;
    end else begin
      word_vld <= 1'b0;
      if (cap) begin
        sh <= sh_next;
        if (last) begin
          cnt      <= '0;
          word_dat <= sh_next;
          word_vld <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end
    end
  end

  a_r6_word_hold: assert property (@(posedge clk) disable iff (rst)
    !word_vld |-> $stable(word_dat));

  a_r6_count_range: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(WORD_W - 1));
endmodule

// File: rtl/serial_retimer.sv
module serial_retimer #(
  parameter sr_pkg::edge_pol_e EDGE_POL    = sr_pkg::EDGE_RISE,
  parameter int                SYNC_STAGES = 2,
  parameter int                DLY_W       = 5,
  parameter int                WORD_W      = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic [DLY_W-1:0]  samp_dly,
  output logic              bit_vld,
  output logic              bit_dat,
  output logic              word_vld,
  output logic [WORD_W-1:0] word_dat,
  output logic              overrun
);
  logic lvl;
  logic lvl_ok;
  logic fire;
  logic cap;

  sr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(ser_clk), .dout(lvl), .dout_ok(lvl_ok)
  );

  sr_edge #(.EDGE_POL(EDGE_POL)) u_edge (
    .clk(clk), .rst(rst), .lvl(lvl), .lvl_ok(lvl_ok), .pulse(fire)
  );

  // Data line sampled directly: the synchroniser delay already follows the link edge
  sr_sampler #(.DLY_W(DLY_W)) u_samp (
    .clk(clk), .rst(rst), .fire(fire), .dly(samp_dly), .din(ser_dat),
    .cap(cap), .bit_vld(bit_vld), .bit_dat(bit_dat), .overrun(overrun)
  );

  sr_packer #(.WORD_W(WORD_W)) u_pack (
    .clk(clk), .rst(rst), .cap(cap), .bit_in(ser_dat),
    .word_vld(word_vld), .word_dat(word_dat)
  );

  a_r3_reset_clear: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bit_vld && !word_vld && !overrun));

  a_r6_word_with_bit: assert property (@(posedge clk) disable iff (rst)
    word_vld |-> bit_vld);
endmodule

// File: tb/serial_retimer_tb.sv
module serial_retimer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_clk = 1'b0;
  logic       ser_dat = 1'b0;
  logic [4:0] samp_dly = '0;

  logic       r_bvld, r_bdat, r_wvld, r_ovr;
  logic [7:0] r_wdat;
  logic       f_bvld, f_bdat, f_wvld, f_ovr;
  logic [7:0] f_wdat;

  serial_retimer #(.EDGE_POL(sr_pkg::EDGE_RISE)) u_dut (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .samp_dly(samp_dly),
    .bit_vld(r_bvld), .bit_dat(r_bdat), .word_vld(r_wvld), .word_dat(r_wdat), .overrun(r_ovr)
  );

  serial_retimer #(.EDGE_POL(sr_pkg::EDGE_FALL)) u_dut_fall (
    .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat), .samp_dly(samp_dly),
    .bit_vld(f_bvld), .bit_dat(f_bdat), .word_vld(f_wvld), .word_dat(f_wdat), .overrun(f_ovr)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit en_r = 0, en_f = 0;
  int due_r[$]; bit bit_r[$];
  int due_w[$]; logic [7:0] word_w[$];
  int due_f[$]; bit bit_f[$];
  logic [7:0] model_sh, last_word;
  int model_n;
  int strobes_r, strobes_f;
  int m_due; bit m_b; logic [7:0] m_w;
  logic prev_r;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int due_of(input int c);
    return c + 3 + int'(samp_dly);   // two sync stages + edge register + delay
  endfunction

  // Monitor, sampled at the falling system edge
  always @(negedge clk) begin
    if (!rst && en_r) begin
      if (r_bvld) begin
        strobes_r++;
        chk(!prev_r, "R5", "bit strobe longer than one cycle", 1, 0);
        if (due_r.size() == 0) chk(0, "R2", "unexpected rising-edge strobe", cyc, 0);
        else begin
          m_due = due_r.pop_front(); m_b = bit_r.pop_front();
          chk(cyc == m_due, "R4", "bit strobe cycle", cyc, m_due);
          chk(r_bdat == m_b, "R5", "captured bit", r_bdat, m_b);
        end
        if (!r_wvld) chk(r_wdat == last_word, "R6", "word hold", r_wdat, last_word);
      end
      if (r_wvld) begin
        if (due_w.size() == 0) chk(0, "R6", "unexpected word strobe", cyc, 0);
        else begin
          m_due = due_w.pop_front(); m_w = word_w.pop_front();
          chk(cyc == m_due, "R6", "word strobe cycle", cyc, m_due);
          chk(r_wdat == m_w, "R6", "word value MSB first", r_wdat, m_w);
          last_word = m_w;
        end
      end
    end
    if (!rst && en_f && f_bvld) begin
      strobes_f++;
      if (due_f.size() == 0) chk(0, "R2", "unexpected falling-edge strobe", cyc, 0);
      else begin
        m_due = due_f.pop_front(); m_b = bit_f.pop_front();
        chk(cyc == m_due, "R4", "falling variant strobe cycle", cyc, m_due);
        chk(f_bdat == m_b, "R2", "falling variant bit", f_bdat, m_b);
      end
    end
    prev_r = r_bvld;
  end

  task automatic push_rise(input bit b);
    due_r.push_back(due_of(cyc)); bit_r.push_back(b);
    model_sh = {model_sh[6:0], b};
    model_n++;
    if (model_n == 8) begin
      due_w.push_back(due_of(cyc)); word_w.push_back(model_sh);
      model_n = 0;
    end
  endtask

  // One serial bit: data changes with the inactive edge, active edge at mid-bit
  task automatic send_bit(input bit b, input int half, input bit fallpol);
    @(negedge clk);
    ser_dat = b;
    ser_clk = fallpol;
    repeat (half) @(negedge clk);
    ser_clk = ~fallpol;
    if (fallpol) begin due_f.push_back(due_of(cyc)); bit_f.push_back(b); end
    else push_rise(b);
    repeat (half - 1) @(negedge clk);
  endtask

  task automatic do_reset(input bit lvl);
    @(negedge clk);
    rst = 1'b1; ser_clk = lvl;
    due_r.delete(); bit_r.delete(); due_w.delete(); word_w.delete();
    due_f.delete(); bit_f.delete();
    model_sh = '0; model_n = 0; last_word = '0;
    strobes_r = 0; strobes_f = 0; prev_r = 1'b0;
    repeat (4) @(negedge clk);
    chk(!r_bvld && !r_wvld && !r_ovr, "R3", "strobes clear in reset",
        {r_bvld, r_wvld, r_ovr}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!r_bvld && !r_wvld && !r_ovr && !f_bvld && !f_ovr, "R3",
        "strobes clear after reset", {r_bvld, r_wvld, r_ovr, f_bvld, f_ovr}, 0);
    chk(r_wdat == 8'h00, "R3", "word zero after reset", r_wdat, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));

    // R1: link clock high through reset: no false rising edge
    do_reset(1'b1);
    en_r = 1; en_f = 1;
    repeat (12) @(negedge clk);
    chk(strobes_r == 0, "R1", "no strobe with clock held high", strobes_r, 0);
    en_f = 0;

    // R8 / R4 / R6 directed: zero delay and a mid-bit delay
    samp_dly = 5'd0;
    for (int i = 7; i >= 0; i--) send_bit(8'hA5 >> i, 12, 1'b0);
    samp_dly = 5'd8;
    for (int i = 7; i >= 0; i--) send_bit(8'h3C >> i, 12, 1'b0);

    // Random bits, delays and bit periods (R2, R4, R5, R6)
    for (int w = 0; w < 6; w++) begin
      samp_dly = 5'($urandom_range(0, 8));
      for (int i = 0; i < 8; i++) send_bit(1'($urandom()), $urandom_range(11, 14), 1'b0);
    end
    repeat (30) @(negedge clk);
    chk(due_r.size() == 0, "R2", "all rising-edge bits strobed", due_r.size(), 0);
    chk(due_w.size() == 0, "R6", "all words strobed", due_w.size(), 0);

    // R1 falling variant: link clock low through reset
    do_reset(1'b0);
    en_r = 1; en_f = 1;
    repeat (12) @(negedge clk);
    chk(strobes_f == 0, "R1", "no strobe with clock held low", strobes_f, 0);
    en_r = 0;
    samp_dly = 5'd4;
    for (int i = 0; i < 16; i++) send_bit(1'($urandom()), 12, 1'b1);
    repeat (30) @(negedge clk);
    chk(due_f.size() == 0 && strobes_f == 16, "R2", "falling variant strobe count",
        strobes_f, 16);

    // R7: second edge while a long delay is pending
    do_reset(1'b0);
    en_r = 1; en_f = 0;
    samp_dly = 5'd15;
    @(negedge clk);
    ser_dat = 1'b1; ser_clk = 1'b1;       // first edge: capture will be dropped
    repeat (8) @(negedge clk);
    ser_clk = 1'b0;
    repeat (2) @(negedge clk);
    chk(r_ovr == 1'b0, "R7", "no overrun before second edge", r_ovr, 0);
    ser_clk = 1'b1;
    due_r.push_back(due_of(cyc)); bit_r.push_back(1'b1);
    repeat (4) @(negedge clk);
    chk(r_ovr == 1'b1, "R7", "overrun set by early edge", r_ovr, 1);
    repeat (30) @(negedge clk);
    chk(strobes_r == 1, "R7", "only restarted capture strobed", strobes_r, 1);
    chk(r_ovr == 1'b1, "R7", "overrun stays set", r_ovr, 1);
    chk(due_r.size() == 0, "R7", "restarted capture arrived", due_r.size(), 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule